// File: doc/BRIEF.md
# Two-Cluster Pixel Weight Learner

This block learns two grey-level cluster centres from one frame of pixels. A background weight and a foreground weight are loaded with preset values when a frame starts. The block then reads pixels one at a time from an external memory through a request/done handshake. For each pixel it finds the weight that lies closer in absolute distance and moves only that weight toward the pixel by a power-of-two fraction of the signed difference.

The memory side marks the last pixel of the frame with an end-of-frame flag that arrives together with its done. When it sees that flag, the block presents both final weights with a one-cycle valid strobe. A downstream stage can then derive a binarisation threshold from the two centres. Work happens only while the frame-start input is held high. Dropping it abandons the frame.

Top module: `cluster_weight_learner`

## Requirements
- R1: After reset, and whenever `frame_start` is low, `rd_req` and `weights_valid` are 0. The cycle after `frame_start` is sampled low, `rd_req` is 0.
- R2: When `frame_start` is sampled high in the idle state, on the next cycle `rd_req` is 1, `rd_addr` is 0, `weight_bg` is INIT_BG (64) and `weight_fg` is INIT_FG (192). This reload happens at every new frame.
- R3: While `rd_req` is high and `rd_done` is low, `rd_addr` holds its value and both weights hold their values, whatever `rd_data` carries.
- R4: Each cycle with `rd_req` and `rd_done` both high (and `frame_start` high) consumes one pixel. If `frame_end` is low, `rd_addr` rises by one on the next cycle and `rd_req` stays high.
- R5: The consumed pixel P updates the nearer weight W to W + floor((P - W) / 2^SHIFT), with SHIFT = 3. The difference is signed and the shift is arithmetic.
- R6: The weight that is not nearer keeps its value for that pixel.
- R7: If |P - weight_bg| equals |P - weight_fg|, the background weight is the one updated.
- R8: Weights stay within 0..255 and never wrap, even after long runs of 0 or 255 pixels.
- R9: A pixel consumed with `frame_end` high is included in the weights. On the next cycle, `weights_valid` is 1 for exactly one cycle and `rd_req` is 0. After that the block is idle with the weights held.
- R10: If `frame_start` falls during a frame, `rd_req` is 0 on the next cycle, no pixel is consumed and no `weights_valid` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Level; high enables frame processing |
| rd_req | output | 1 | Pixel read request |
| rd_addr | output | ADDR_W (16) | Address of the requested pixel |
| rd_done | input | 1 | Memory side: `rd_data` is valid this cycle |
| rd_data | input | PIX_W (8) | Pixel value, unsigned |
| frame_end | input | 1 | Qualified by `rd_done`; marks the last pixel |
| weight_bg | output | PIX_W (8) | Background cluster centre |
| weight_fg | output | PIX_W (8) | Foreground cluster centre |
| weights_valid | output | 1 | One-cycle strobe with the final weights |

## Verification
The hardest case to reach from the ports is the exact distance tie, combined with a weight near the range limits where the floor of a negative shift moves the weight by one. From preset weights, a tie only happens on a single pixel value. The stimulus therefore sweeps all 256 pixel values, each as a one-pixel frame, so that the tie and every rounding case are hit with known starting weights. Long multi-pixel frames with random wait states and saturated pixel runs then drive the weights into the regions near 0 and 255.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cwl_state_e;

  localparam int unsigned NUM_CLUSTERS = 2;
endpackage

// File: rtl/cwl_read_seq.sv
module cwl_read_seq
  import cwl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              rd_done,
  input  logic              frame_end,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              load_init,
  output logic              take_pix,
  output logic              weights_valid
);
  cwl_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic addr_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (frame_start) state_d = ST_RUN;
      ST_RUN: begin
        if (!frame_start)              state_d = ST_IDLE;
        else if (rd_done && frame_end) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_init = (state_q == ST_IDLE) && frame_start;
  assign take_pix  = (state_q == ST_RUN) && frame_start && rd_done;
  assign addr_en   = load_init || take_pix;

  always_comb begin
    addr_d = addr_q;
    if (load_init)     addr_d = '0;
    else if (take_pix) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign rd_req        = (state_q == ST_RUN);
  assign rd_addr       = addr_q;
  assign weights_valid = (state_q == ST_DONE);

  assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> !rd_req);
  assert_abort_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !frame_start) |=> (!rd_req && !weights_valid));
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done && frame_start) |=> $stable(rd_addr));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && frame_start && !frame_end) |=> (rd_req && rd_addr == $past(rd_addr) + 1'b1));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    weights_valid |=> !weights_valid);
  assert_last_pixel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && frame_start && frame_end) |=> (weights_valid && !rd_req));
endmodule

// File: rtl/cwl_update_dp.sv
module cwl_update_dp
  import cwl_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned SHIFT = 3
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] w_bg,
  input  logic [PIX_W-1:0] w_fg,
  output logic [PIX_W-1:0] nxt_bg,
  output logic [PIX_W-1:0] nxt_fg,
  output logic             pick_fg
);
  localparam int unsigned DW = PIX_W + 1;
  localparam int unsigned SW = PIX_W + 2;
  localparam logic signed [SW-1:0] PIX_MAX = SW'((1 << PIX_W) - 1);

  logic [PIX_W-1:0]        w_in  [NUM_CLUSTERS];
  logic signed [DW-1:0]    diff  [NUM_CLUSTERS];
  logic [DW-1:0]           mag   [NUM_CLUSTERS];
  logic signed [DW-1:0]    step  [NUM_CLUSTERS];
  logic signed [SW-1:0]    sum   [NUM_CLUSTERS];
  logic [PIX_W-1:0]        moved [NUM_CLUSTERS];

  assign w_in[0] = w_bg;
  assign w_in[1] = w_fg;

  for (genvar g = 0; g < NUM_CLUSTERS; g++) begin : g_cluster
    always_comb begin
      diff[g] = $signed({1'b0, pix}) - $signed({1'b0, w_in[g]});
      mag[g]  = diff[g][DW-1] ? DW'(-diff[g]) : DW'(diff[g]);
      step[g] = diff[g] >>> SHIFT;
      sum[g]  = $signed({2'b00, w_in[g]}) + SW'(step[g]);
      if (sum[g] < 0)            moved[g] = '0;
      else if (sum[g] > PIX_MAX) moved[g] = '1;
      else                       moved[g] = sum[g][PIX_W-1:0];
    end
  end

  // Tie goes to the background weight (R7)
  assign pick_fg = (mag[1] < mag[0]);
  assign nxt_bg  = pick_fg ? w_bg : moved[0];
  assign nxt_fg  = pick_fg ? moved[1] : w_fg;

  always_comb begin
    if (!$isunknown({pix, w_bg, w_fg})) begin
      assert_moves_closer_R5: assert ((pick_fg ? mag[1] : mag[0]) >=
        (pick_fg ? DW'(pix > nxt_fg ? pix - nxt_fg : nxt_fg - pix)
                 : DW'(pix > nxt_bg ? pix - nxt_bg : nxt_bg - pix)));
    end
  end
endmodule

// File: rtl/cluster_weight_learner.sv
module cluster_weight_learner
  import cwl_pkg::*;
#(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHIFT   = 3,
  parameter int unsigned INIT_BG = 64,
  parameter int unsigned INIT_FG = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  input  logic [PIX_W-1:0]  rd_data,
  input  logic              frame_end,
  output logic [PIX_W-1:0]  weight_bg,
  output logic [PIX_W-1:0]  weight_fg,
  output logic              weights_valid
);
  localparam logic [PIX_W-1:0] BG0 = PIX_W'(INIT_BG);
  localparam logic [PIX_W-1:0] FG0 = PIX_W'(INIT_FG);

  logic load_init, take_pix, pick_fg, w_en;
  logic [PIX_W-1:0] bg_q, fg_q, bg_d, fg_d, upd_bg, upd_fg;

  cwl_read_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .rd_done       (rd_done),
    .frame_end     (frame_end),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .load_init     (load_init),
    .take_pix      (take_pix),
    .weights_valid (weights_valid)
  );

  cwl_update_dp #(.PIX_W(PIX_W), .SHIFT(SHIFT)) u_dp (
    .pix     (rd_data),
    .w_bg    (bg_q),
    .w_fg    (fg_q),
    .nxt_bg  (upd_bg),
    .nxt_fg  (upd_fg),
    .pick_fg (pick_fg)
  );

  assign w_en = load_init || take_pix;

  always_comb begin
    bg_d = load_init ? BG0 : upd_bg;
    fg_d = load_init ? FG0 : upd_fg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_q <= BG0;
      fg_q <= FG0;
    end else if (w_en) begin
      bg_q <= bg_d;
      fg_q <= fg_d;
    end
  end

  assign weight_bg = bg_q;
  assign weight_fg = fg_q;

  assert_single_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && frame_start) |=> ($stable(weight_bg) || $stable(weight_fg)));
  assert_hold_no_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_req && rd_done) && !(frame_start && !rd_req)) |=> ($stable(weight_bg) && $stable(weight_fg)));
  assert_tie_bg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pix && !pick_fg) |=> $stable(weight_fg));
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !weights_valid && frame_start) |=> (weight_bg == BG0 && weight_fg == FG0 && rd_addr == '0));
endmodule

// File: tb/cluster_weight_learner_tb.sv
module cluster_weight_learner_tb_top;
  localparam int SH = 3;
  logic clk, rst_n, frame_start, rd_req, rd_done, frame_end, weights_valid;
  logic [15:0] rd_addr;
  logic [7:0] rd_data, weight_bg, weight_fg;
  int checks = 0, fails = 0;
  int mbg, mfg;
  logic [15:0] lfsr = 16'hACE1;

  cluster_weight_learner dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data), .frame_end(frame_end),
    .weight_bg(weight_bg), .weight_fg(weight_fg), .weights_valid(weights_valid));

  initial clk = 0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int nxt_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr);
  endfunction

  function automatic int floor_step(input int d);
    if (d >= 0) return d >> SH;
    return -((-d + (1 << SH) - 1) >> SH);
  endfunction

  function automatic int absv(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic model(input int p);
    if (absv(p - mbg) <= absv(p - mfg)) mbg = mbg + floor_step(p - mbg);
    else                                mfg = mfg + floor_step(p - mfg);
    if (mbg < 0) mbg = 0;
    if (mbg > 255) mbg = 255;
    if (mfg < 0) mfg = 0;
    if (mfg > 255) mfg = 255;
  endtask

  task automatic begin_frame();
    frame_start = 1;
    step();
    mbg = 64; mfg = 192;
    chk("R2 rd_req", int'(rd_req), 1);
    chk("R2 rd_addr", int'(rd_addr), 0);
    chk("R2 weight_bg", int'(weight_bg), 64);
    chk("R2 weight_fg", int'(weight_fg), 192);
  endtask

  task automatic feed(input int p, input bit last, input int waits, input string tag);
    int a0;
    a0 = int'(rd_addr);
    for (int w = 0; w < waits; w++) begin
      rd_data = 8'(nxt_lfsr());
      step();
      chk("R3 addr hold", int'(rd_addr), a0);
      chk("R3 bg hold", int'(weight_bg), mbg);
      chk("R3 fg hold", int'(weight_fg), mfg);
    end
    rd_data = 8'(p); rd_done = 1; frame_end = last;
    step();
    rd_done = 0; frame_end = 0;
    model(p);
    chk({tag, " weight_bg"}, int'(weight_bg), mbg);
    chk({tag, " weight_fg"}, int'(weight_fg), mfg);
    if (!last) begin
      chk("R4 addr step", int'(rd_addr), (a0 + 1) & 16'hFFFF);
      chk("R4 rd_req", int'(rd_req), 1);
    end else begin
      chk("R9 weights_valid", int'(weights_valid), 1);
      chk("R9 rd_req low", int'(rd_req), 0);
      frame_start = 0;
      step();
      chk("R9 valid pulse end", int'(weights_valid), 0);
      chk("R9 bg held", int'(weight_bg), mbg);
      chk("R9 fg held", int'(weight_fg), mfg);
    end
  endtask

  initial begin
    rst_n = 0; frame_start = 0; rd_done = 0; rd_data = 0; frame_end = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 reset rd_req", int'(rd_req), 0);
    chk("R1 reset valid", int'(weights_valid), 0);
    chk("R1 reset bg", int'(weight_bg), 64);
    chk("R1 reset fg", int'(weight_fg), 192);
    for (int i = 0; i < 4; i++) begin
      rd_done = 1; rd_data = 8'd7; step();
      chk("R1 idle rd_req", int'(rd_req), 0);
      chk("R1 idle bg", int'(weight_bg), 64);
    end
    rd_done = 0;

    // Sweep every pixel value as a one-pixel frame (R5, R6, R7, R8)
    for (int p = 0; p < 256; p++) begin
      begin_frame();
      feed(p, 1'b1, p % 2, (p == 128) ? "R7 tie" : "R5 R6 sweep");
    end

    // Long frame with random pixels and wait states
    begin_frame();
    for (int i = 0; i < 80; i++) feed(nxt_lfsr() & 255, 1'b0, i % 3, "R5 R6 frame");
    feed(200, 1'b1, 0, "R5 last");

    // Saturated runs toward both range limits
    begin_frame();
    for (int i = 0; i < 60; i++) feed(255, 1'b0, 0, "R8 high run");
    for (int i = 0; i < 60; i++) feed(0, 1'b0, 0, "R8 low run");
    chk("R8 bg low bound", int'(weight_bg), mbg);
    feed(0, 1'b1, 0, "R8 last");

    // Abort mid frame, then restart reloads presets
    begin_frame();
    feed(10, 1'b0, 0, "R5 pre-abort");
    feed(240, 1'b0, 1, "R5 pre-abort");
    frame_start = 0; rd_done = 1; rd_data = 8'd0; frame_end = 1;
    step();
    rd_done = 0; frame_end = 0;
    chk("R10 rd_req low", int'(rd_req), 0);
    chk("R10 no valid", int'(weights_valid), 0);
    chk("R10 bg untouched", int'(weight_bg), mbg);
    chk("R10 fg untouched", int'(weight_fg), mfg);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R10 no valid later", int'(weights_valid), 0);
      chk("R1 idle after abort", int'(rd_req), 0);
    end
    begin_frame();
    feed(100, 1'b1, 2, "R2 restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule